// File: doc/BRIEF.md
# Packetized Register Access Decoder

This block sits behind a byte-wide host link that carries traffic both ways. It collects incoming bytes into 32-bit control frames. Each frame holds a 4-bit command, a 12-bit register address and a 16-bit data word. It checks the command of each frame, and a frame changes nothing until its last byte has arrived and the command is known to be legal.

A write frame updates one register in a bank of 16-bit control registers. The update is announced to downstream logic with a single-cycle strobe that carries the address and the new value. A read frame has the same layout as a write. The block answers it by sending a four-byte response back over the link. Frames with any other command are dropped. Addresses beyond the implemented bank ignore writes and read as zero.

Top module: `ctrl_pkt_regs`

## Requirements
- R1: A frame is four bytes sent most-significant first. After assembly, bits 31:28 are the command, bits 27:16 the address and bits 15:0 the data.
- R2: A frame with command 0x1 and an implemented address stores its data field in that register, and a later read returns the new value.
- R3: A write to an implemented address raises `wr_strobe` for exactly one cycle, starting on the cycle after the last byte is taken, with `wr_addr` and `wr_data` equal to the frame's fields.
- R4: A frame with command 0x2 produces on `tx_byte` the four bytes of {4'h2, address, register value}, most-significant byte first, with `tx_valid` rising on the cycle after the last byte is taken.
- R5: A frame with any command other than 0x1 or 0x2 raises no strobe, sends no response and leaves every register unchanged.
- R6: The data field of a read frame is ignored: it changes no register, and the response carries the stored value.
- R7: At addresses at or above NUM_REGS (32 by default), writes raise no strobe and change nothing, and reads return data 0x0000 with the address echoed.
- R8: Nothing is committed before the fourth byte is taken. A high `rx_sync` discards any partly assembled frame, and the next byte starts a new frame.
- R9: While a response is pending, `rx_ready` is low and incoming bytes are ignored. While `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.
- R10: A synchronous active-high reset clears every register to 0x0000, drops `tx_valid` and `wr_strobe`, and leaves `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sync | input | 1 | Discards any partly received frame |
| rx_valid | input | 1 | Incoming byte is present |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Response byte is present |
| tx_byte | output | 8 | Response byte |
| tx_ready | input | 1 | Host takes the response byte |
| wr_strobe | output | 1 | One-cycle pulse for a committed write |
| wr_addr | output | 12 | Address of the committed write |
| wr_data | output | 16 | Value of the committed write |

## Verification
Both results of a frame are due one cycle after the edge that takes its fourth byte. On that cycle the strobe fires with its address and value, or the first response byte appears. Each later response byte follows one cycle after the edge on which `tx_ready` was high. The bench drives inputs and samples outputs on the falling edge. It reads the strobe on the falling edge right after the last byte, and at every earlier falling edge it confirms the strobe stayed low. It reads each response byte before raising `tx_ready` for one edge. It also holds `tx_ready` low for a few cycles to confirm that the byte does not change.

// File: rtl/ctrl_pkt_regs.sv
module ctrl_pkt_regs #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_sync,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = 4 + ADDR_W + DATA_W;
  localparam int NBYTES  = FRAME_W / 8;
  localparam int CNT_W   = $clog2(NBYTES);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int HOLD_W  = FRAME_W - 8;
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(NBYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [3:0] CMD_WR = 4'h1;
  localparam logic [3:0] CMD_RD = 4'h2;

  logic [DATA_W-1:0]  regs [NUM_REGS];
  logic [CNT_W-1:0]   rx_cnt;
  logic [HOLD_W-1:0]  rx_hold;
  logic [FRAME_W-1:0] tx_buf;
  logic [CNT_W-1:0]   tx_cnt;
  logic               tx_busy;

  wire                 rx_take = rx_valid && rx_ready && !rx_sync;
  wire                 rx_last = rx_take && (rx_cnt == LAST_CNT);
  wire [FRAME_W-1:0]   frame   = {rx_hold, rx_byte};
  wire [3:0]           f_cmd   = frame[FRAME_W-1 -: 4];
  wire [ADDR_W-1:0]    f_addr  = frame[DATA_W +: ADDR_W];
  wire [DATA_W-1:0]    f_data  = frame[DATA_W-1:0];
  wire                 f_hit   = f_addr <= LAST_ADDR;
  wire                 do_wr   = rx_last && (f_cmd == CMD_WR) && f_hit;
  wire                 do_rd   = rx_last && (f_cmd == CMD_RD);
  wire [DATA_W-1:0]    rd_val  = f_hit ? regs[f_addr[IDX_W-1:0]] : '0;

  assign rx_ready = !tx_busy;
  assign tx_valid = tx_busy;
  assign tx_byte  = tx_buf[FRAME_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst || rx_sync) begin
      rx_cnt  <= '0;
      rx_hold <= '0;
    end else if (rx_take) begin
      rx_cnt  <= rx_last ? '0 : rx_cnt + 1'b1;
      rx_hold <= {rx_hold[HOLD_W-9:0], rx_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= do_wr;
      if (do_wr) begin
        regs[f_addr[IDX_W-1:0]] <= f_data;
        wr_addr <= f_addr;
        wr_data <= f_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      tx_cnt  <= '0;
      tx_buf  <= '0;
    end else if (do_rd) begin
      tx_busy <= 1'b1;
      tx_cnt  <= '0;
      tx_buf  <= {CMD_RD, f_addr, rd_val};
    end else if (tx_busy && tx_ready) begin
      tx_buf <= tx_buf << 8;
      tx_cnt <= tx_cnt + 1'b1;
      if (tx_cnt == LAST_CNT) tx_busy <= 1'b0;
    end
  end

  // R10
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !tx_valid && !wr_strobe && rx_ready);
  // R3
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);
  // R7
  a_r7_strobe_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> wr_addr <= LAST_ADDR);
  // R8
  a_r8_commit_on_byte: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $past(rx_valid && rx_ready && !rx_sync));
  // R9
  a_r9_rx_blocked: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !rx_ready);
  // R9
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  // R4
  a_r4_resp_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_byte[7:4] == CMD_RD);
endmodule

// File: tb/ctrl_pkt_regs_test.sv
module ctrl_pkt_regs_test;
  logic clk = 1'b0, rst = 1'b1, rx_sync = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_ready, tx_valid, wr_strobe;
  logic [7:0] tx_byte;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ctrl_pkt_regs uut (.clk, .rst, .rx_sync, .rx_valid, .rx_byte, .rx_ready,
    .tx_valid, .tx_byte, .tx_ready, .wr_strobe, .wr_addr, .wr_data);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        s_stb, s_early;
  logic [11:0] s_addr;
  logic [15:0] s_data;

  task automatic send_frame(logic [3:0] c, logic [11:0] a, logic [15:0] d);
    logic [31:0] f = {c, a, d};
    s_early = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      if (wr_strobe) s_early = 1'b1;
      rx_valid = 1'b1;
      rx_byte  = f[i*8 +: 8];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    s_stb = wr_strobe; s_addr = wr_addr; s_data = wr_data;
  endtask

  task automatic read_reg(string tag, logic [11:0] a, logic [15:0] dfield,
                          logic [15:0] exp, int stall);
    logic [31:0] got, want;
    want = {4'h2, a, exp};
    send_frame(4'h2, a, dfield);
    check({tag, " R4 tx_valid after read"}, tx_valid, 1'b1);
    check({tag, " R9 rx_ready low"}, rx_ready, 1'b0);
    check({tag, " R6 no strobe on read"}, s_stb, 1'b0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check({tag, " R9 hold"}, {tx_valid, tx_byte}, {1'b1, want[31:24]});
    end
    for (int i = 3; i >= 0; i--) begin
      got[i*8 +: 8] = tx_byte;
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    check({tag, " R4 response"}, got, want);
    check({tag, " R4 tx idle"}, {tx_valid, rx_ready}, 2'b01);
  endtask

  task automatic write_reg(string tag, logic [11:0] a, logic [15:0] d);
    send_frame(4'h1, a, d);
    check({tag, " R8 no early strobe"}, s_early, 1'b0);
    check({tag, " R3 strobe"}, {s_stb, s_addr, s_data}, {1'b1, a, d});
    @(negedge clk);
    check({tag, " R3 strobe one cycle"}, wr_strobe, 1'b0);
  endtask

  task automatic t_reset;
    check("R10 rx_ready", rx_ready, 1'b1);
    check("R10 idle", {tx_valid, wr_strobe}, 2'b00);
    read_reg("R10 reg zero", 12'h005, 16'h0, 16'h0000, 0);
  endtask

  task automatic t_write_read;
    write_reg("R2 w3", 12'h003, 16'hA5C3);
    read_reg("R1 R2 r3", 12'h003, 16'h0, 16'hA5C3, 0);
    write_reg("R2 w0", 12'h000, 16'h1234);
    write_reg("R2 w31", 12'h01F, 16'hFEDC);
    read_reg("R2 r0", 12'h000, 16'h0, 16'h1234, 2);
    read_reg("R2 r31", 12'h01F, 16'h0, 16'hFEDC, 0);
  endtask

  task automatic t_bad_cmd;
    logic [3:0] bad [3] = '{4'h0, 4'h3, 4'hF};
    foreach (bad[i]) begin
      send_frame(bad[i], 12'h003, 16'h1111);
      check("R5 no strobe", s_stb, 1'b0);
      check("R5 no response", tx_valid, 1'b0);
    end
    read_reg("R5 unchanged", 12'h003, 16'h0, 16'hA5C3, 0);
  endtask

  task automatic t_read_data;
    read_reg("R6 data ignored", 12'h003, 16'hFFFF, 16'hA5C3, 0);
    read_reg("R6 still", 12'h003, 16'h0, 16'hA5C3, 0);
  endtask

  task automatic t_unimpl;
    send_frame(4'h1, 12'h020, 16'h7777);
    check("R7 no strobe 0x020", s_stb, 1'b0);
    send_frame(4'h1, 12'hFFF, 16'h7777);
    check("R7 no strobe 0xFFF", s_stb, 1'b0);
    read_reg("R7 read 0xFFF", 12'hFFF, 16'h0, 16'h0000, 0);
    read_reg("R7 alias 0x000", 12'h000, 16'h0, 16'h1234, 0);
  endtask

  task automatic t_sync;
    logic [31:0] f = {4'h1, 12'h007, 16'h5555};
    for (int i = 3; i >= 1; i--) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = f[i*8 +: 8];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8 no commit at 3 bytes", wr_strobe, 1'b0);
    rx_sync = 1'b1;
    @(negedge clk);
    rx_sync = 1'b0;
    write_reg("R8 after sync", 12'h008, 16'h0BAD);
    read_reg("R8 partial dropped", 12'h007, 16'h0, 16'h0000, 0);
  endtask

  task automatic t_busy;
    logic [31:0] f = {4'h1, 12'h009, 16'hBEEF};
    send_frame(4'h2, 12'h008, 16'h0);
    for (int i = 3; i >= 0; i--) begin
      check("R9 rx_ready low", rx_ready, 1'b0);
      rx_valid = 1'b1; rx_byte = f[i*8 +: 8];
      @(negedge clk);
      check("R9 no strobe while busy", wr_strobe, 1'b0);
    end
    rx_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    end
    read_reg("R9 dropped write", 12'h009, 16'h0, 16'h0000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_bad_cmd();
    t_read_data();
    t_unimpl();
    t_sync();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule